// File: doc/BRIEF.md
# Core Data Register With Inhibit

This block is the per-bit word register that sits between the sense path and the requester of a memory whose reads are destructive. During the read half of a cycle it collects the bits reported by the sense path while a strobe qualifies them. During the restore half it drives one digit enable per bit, so that every bit holding a one is written back. On store cycles the requester preloads the word to be written and raises an inhibit flag. The sensed word is then thrown away, and the preloaded word is the one restored.

Sense inputs can only set bits; nothing on the sense side clears one. The requester clears the register by inserting a zero word at the start of each cycle. If that clear is skipped, an inserted word is ORed into the current contents, so several words can be merged. The word width is a parameter with a default of 59.

Top module: `core_data_reg`

## Requirements
- R1: A bit is set from the sense side only in a cycle where its sense input is 1 and the strobe is high at the same time. A sense 1 without the strobe, or the strobe without a sense 1, leaves the bit at 0.
- R2: While inhibit is high, no sense input sets any bit. With no load or clear in the same cycle, the word is held unchanged.
- R3: A clear request with no load and no strobe makes the word all zeros on the next clock.
- R4: A load without clear makes the next word equal to the current word ORed bitwise with the load data.
- R5: A clear and a load in the same cycle, with no strobe, make the next word equal to the load data alone.
- R6: A strobed sense 0 never clears a bit that already holds a 1.
- R7: Digit enables are registered. When the digit phase is high in a cycle, the digit enable vector after the next clock equals the word held during that cycle.
- R8: When the digit phase is low in a cycle, every digit enable is 0 after the next clock.
- R9: After reset, the word and all digit enables are 0.
- R10: In a store cycle, the sequence is: preload the store word, assert inhibit, apply strobed sense data, then run the digit phase. The digit enables then equal the preloaded word, not the sensed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear the word (insert a zero word) |
| strobe_i | input | 1 | Sense strobe; qualifies sense_i |
| sense_i | input | WIDTH | Sense path bits |
| inhibit_i | input | 1 | Blocks sense bits from setting the word (store cycles) |
| load_i | input | 1 | Insert load_data_i into the word |
| load_data_i | input | WIDTH | Word inserted by the requester |
| digit_phase_i | input | 1 | Restore digit phase enable |
| word_o | output | WIDTH | Held word |
| digit_en_o | output | WIDTH | Registered per-bit digit enables |

## Verification
The hardest case to reach from the ports is a store cycle. Its requirements are only met when several control inputs line up in the right order: a clear together with a preload, then inhibit held while strobed sense data that differ from the preload arrive, and then the digit phase. The bench drives this whole sequence in a single task. It then compares the digit enables with the preloaded word, and confirms they differ from the sensed word. The OR merge is exercised from a non-zero starting word, so that set and kept bits are both visible.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
   typedef struct packed {
      logic clr;
      logic load;
      logic strobe;
      logic inhibit;
   } cdr_ctl_t;
endpackage

// File: rtl/cdr_bit_cell.sv
module cdr_bit_cell
   import cdr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  cdr_ctl_t ctl,
   input  logic     sense_b,
   input  logic     load_b,
   output logic     q
);
   logic keep_b;
   logic sense_set_b;
   logic load_set_b;

   always_comb begin
      keep_b      = q & ~ctl.clr;
      sense_set_b = sense_b & ctl.strobe & ~ctl.inhibit;
      load_set_b  = load_b & ctl.load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= keep_b | sense_set_b | load_set_b;
   end

   // R1
   sense_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !ctl.load && !(ctl.strobe && sense_b)) |=> !q);
   // R2
   inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.inhibit && !ctl.load && !ctl.clr) |=> (q == $past(q)));
   // R6
   sense_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !ctl.clr) |=> q);
   // R5
   clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr && ctl.load && !ctl.strobe) |=> (q == $past(load_b)));
endmodule

// File: rtl/cdr_digit_stage.sv
module cdr_digit_stage #(
   parameter int WIDTH = 59
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] dig
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dig <= ZERO;
      else if (phase) dig <= word;
      else            dig <= ZERO;
   end

   // R8
   digit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phase |=> (dig == ZERO));
   // R7
   digit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase |=> (dig == $past(word)));
endmodule

// File: rtl/core_data_reg.sv
module core_data_reg
   import cdr_pkg::*;
#(
   parameter int WIDTH = 59
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             strobe_i,
   input  logic [WIDTH-1:0] sense_i,
   input  logic             inhibit_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_data_i,
   input  logic             digit_phase_i,
   output logic [WIDTH-1:0] word_o,
   output logic [WIDTH-1:0] digit_en_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("core_data_reg: WIDTH must be at least 1");
   end

   cdr_ctl_t ctl;
   always_comb begin
      ctl.clr     = clr_i;
      ctl.load    = load_i;
      ctl.strobe  = strobe_i;
      ctl.inhibit = inhibit_i;
   end

   logic [MSB:0] word_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      cdr_bit_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctl     (ctl),
         .sense_b (sense_i[b]),
         .load_b  (load_data_i[b]),
         .q       (word_q[b])
      );
   end

   cdr_digit_stage #(.WIDTH(WIDTH)) u_digit (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (digit_phase_i),
      .word  (word_q),
      .dig   (digit_en_o)
   );

   assign word_o = word_q;

   // R3
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !load_i && !strobe_i) |=> (word_o == '0));
   // R4
   load_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i && !strobe_i) |=> (word_o == ($past(word_o) | $past(load_data_i))));
endmodule

// File: tb/core_data_reg_test.sv
module core_data_reg_test;
   localparam int  W      = 59;
   localparam time CLK_NS = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clr_i = 1'b0, strobe_i = 1'b0, inhibit_i = 1'b0;
   logic         load_i = 1'b0, digit_phase_i = 1'b0;
   logic [W-1:0] sense_i = '0, load_data_i = '0;
   logic [W-1:0] word_o, digit_en_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_NS/2) clk = ~clk;

   core_data_reg #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .strobe_i(strobe_i),
      .sense_i(sense_i), .inhibit_i(inhibit_i), .load_i(load_i),
      .load_data_i(load_data_i), .digit_phase_i(digit_phase_i),
      .word_o(word_o), .digit_en_o(digit_en_o)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      clr_i = 0; strobe_i = 0; inhibit_i = 0; load_i = 0;
      digit_phase_i = 0; sense_i = '0; load_data_i = '0;
   endtask

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic put_word(logic [W-1:0] v);
      idle(); clr_i = 1; load_i = 1; load_data_i = v; tick(); idle();
   endtask

   task automatic t_reset();
      chk("R9 word", word_o, '0);
      chk("R9 digit", digit_en_o, '0);
   endtask

   task automatic t_strobe_gating();
      put_word('0);
      sense_i = 59'h7FF_FFFF_FFFF_FFFF; tick();
      chk("R1 sense without strobe", word_o, '0);
      idle(); strobe_i = 1; tick();
      chk("R1 strobe without sense", word_o, '0);
      sense_i = 59'h123_4567_89AB_CDEF; tick();
      chk("R1 strobe and sense", word_o, 59'h123_4567_89AB_CDEF);
      idle();
   endtask

   task automatic t_inhibit();
      put_word(59'h0F0_0000_0000_000F);
      inhibit_i = 1; strobe_i = 1; sense_i = 59'h7FF_FFFF_FFFF_FFFF; tick();
      chk("R2 inhibit blocks sense", word_o, 59'h0F0_0000_0000_000F);
      idle();
   endtask

   task automatic t_clear();
      put_word(59'h5A5_0F0F_1234_8001);
      clr_i = 1; tick();
      chk("R3 clear", word_o, '0);
      idle();
   endtask

   task automatic t_or_merge();
      put_word(59'h00F_0000_FFFF_0000);
      load_i = 1; load_data_i = 59'h0F0_F0F0_0000_0001; tick();
      chk("R4 load OR", word_o, 59'h0FF_F0F0_FFFF_0001);
      idle();
   endtask

   task automatic t_clear_load();
      put_word(59'h7FF_FFFF_FFFF_FFFF);
      clr_i = 1; load_i = 1; load_data_i = 59'h001_0203_0405_0607; tick();
      chk("R5 clear with load", word_o, 59'h001_0203_0405_0607);
      idle();
   endtask

   task automatic t_sense_no_clear();
      put_word(59'h3C3_C3C3_C3C3_C3C3);
      strobe_i = 1; sense_i = 59'h400_0000_0000_0000; tick();
      chk("R6 sense keeps ones", word_o, 59'h7C3_C3C3_C3C3_C3C3);
      idle();
   endtask

   task automatic t_digit();
      put_word(59'h2AA_5555_AAAA_5555);
      chk("R8 digit idle", digit_en_o, '0);
      digit_phase_i = 1; tick();
      chk("R7 digit follows word", digit_en_o, 59'h2AA_5555_AAAA_5555);
      digit_phase_i = 0; tick();
      chk("R8 digit drops", digit_en_o, '0);
      idle();
   endtask

   task automatic t_store_cycle();
      logic [W-1:0] store_w = 59'h135_7913_5791_3579;
      logic [W-1:0] sensed  = 59'h6CA_8642_0ECA_8642;
      put_word(store_w);
      inhibit_i = 1; strobe_i = 1; sense_i = sensed; tick();
      idle(); digit_phase_i = 1; tick();
      chk("R10 restore writes store word", digit_en_o, store_w);
      total++;
      if (digit_en_o == (store_w | sensed)) begin
         bad++;
         $display("FAIL R10 sensed bits leaked act=%h exp=%h", digit_en_o, store_w);
      end
      idle(); tick();
   endtask

   initial begin
      #(CLK_NS * 150000);
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_strobe_gating();
      t_inhibit();
      t_clear();
      t_or_merge();
      t_clear_load();
      t_sense_no_clear();
      t_digit();
      t_store_cycle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule